// File: doc/BRIEF.md
# Line-Aliasing Outstanding Request Tracker

The tracker sits between a core's memory pipeline and its first-level cache controller. It keeps a record of every request that is in flight. Each incoming request gives a byte address, an access size and a request kind. The tracker classifies the kind into a primary type, which it uses for its own bookkeeping, and a secondary type, which it sends downstream. It then files the request by cache-line address into one of two fully associative tables. Loads and fetches go to the read table. Every request that may modify a line goes to the write table.

A request is refused in two cases. It is refused with a full status when the tracker or the chosen table has no room. It is refused with an aliased status when its line is already held in either table. Four saturating event counters record the kinds of aliasing refusal. The controller retires an entry by naming its line and its table. A retirement that names nothing held is flagged as an error and changes no state. An age watchdog runs periodically while requests are outstanding. It raises a sticky deadlock flag when it finds an entry at least the threshold number of cycles old.

Top module: `line_alias_tracker`

## Requirements
- R1: When the outstanding count is already `MAX_OUT` or more, a request gets status 2 (full). Nothing is recorded, no event counter moves, and `iss_valid` stays low.
- R2: When the table chosen for a request has no free entry, the request gets status 2 (full) even if the outstanding count is below `MAX_OUT`.
- R3: A request whose line (`req_addr` above bit `LINE_OFF`-1) is already held in either table gets status 1 (aliased) and is not recorded. An accepted request gets status 0 (issued). `iss_valid` pulses with status 0 only.
- R4: Aliasing refusals increment saturating counters: write-class on a read-held line (`alias_st_ld`), write-class on a write-held line (`alias_st_st`), read-class on a read-held line (`alias_ld_ld`), read-class on a write-held line (`alias_ld_st`). Each counter holds at its all-ones value.
- R5: Kind 4 (atomic-pair read) issues primary 4 and secondary 4 (atomic). Kind 5 (atomic-pair write) issues primary 5 and secondary 4.
- R6: Kind 6 (locked read-modify-write read) issues primary 6 and kind 7 (locked write) issues primary 7, both with secondary 2 (store).
- R7: Kind 0 (read) with `req_store_check` high issues primary 8 and secondary 2. Without it, kind 0 issues primary 0 and secondary 0. Kind 1 (fetch) issues 1/1, kind 2 (store) 2/2, kind 3 (flush) 3/3. Primaries 0 and 1 use the read table and all others use the write table.
- R8: `iss_lat` is `ILAT` for secondary 1 (fetch) and `DLAT` otherwise. Both must be nonzero. `iss_addr` and `iss_size` repeat the request.
- R9: While entries are outstanding, a check runs every `THRESH` cycles. It sets the sticky `deadlock` output if any entry's age is `THRESH` or more. An entry retired at an age below `THRESH` never sets it. An entry held `2*THRESH` cycles always does.
- R10: A completion (`cpl_valid`, `cpl_line`, `cpl_write` choosing the write table) removes the matching entry, after which the line can be accepted again. A completion that matches nothing pulses `cpl_err` one cycle later and leaves the count unchanged.
- R11: `rsp_valid`, `rsp_status` and the issue outputs appear in the cycle after the request is presented. After reset all outputs are zero.
- R12: `out_count` equals the number of entries held across both tables and never exceeds `MAX_OUT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request presented this cycle |
| req_addr | input | ADDR_W | Request byte address |
| req_size | input | SIZE_W | Access size, passed downstream |
| req_kind | input | 3 | Request kind code (R5-R7) |
| req_store_check | input | 1 | Read carries a store-check flag |
| cpl_valid | input | 1 | Completion presented this cycle |
| cpl_line | input | ADDR_W-LINE_OFF | Line address being retired |
| cpl_write | input | 1 | 1 retires from the write table, 0 from the read table |
| rsp_valid | output | 1 | Response to last cycle's request |
| rsp_status | output | 2 | 0 issued, 1 aliased, 2 full |
| iss_valid | output | 1 | Request issued downstream |
| iss_addr | output | ADDR_W | Issued address |
| iss_size | output | SIZE_W | Issued size |
| iss_prim | output | 4 | Primary type |
| iss_sec | output | 3 | Secondary type |
| iss_lat | output | LAT_W | Hit latency attached |
| cpl_err | output | 1 | Last cycle's completion matched no entry |
| out_count | output | $clog2(RD_DEPTH+WR_DEPTH+1) | Entries outstanding |
| alias_st_ld | output | EV_W | Write-class on read-held line events |
| alias_st_st | output | EV_W | Write-class on write-held line events |
| alias_ld_ld | output | EV_W | Read-class on read-held line events |
| alias_ld_st | output | EV_W | Read-class on write-held line events |
| deadlock | output | 1 | Sticky age-watchdog flag |

## Verification
The bench targets cross-table aliasing in both directions. A design that searched only the request's own table would issue a store to a line with a pending load. It also tests both full causes, and uses an aliasing request while the tracker is full. A design that ranked aliasing above fullness would bump a counter there. Counter saturation is driven past the all-ones value, so a wrapping counter would fall back to a small value. Completions are aimed at absent lines and at the wrong table to catch a tracker that frees by line alone. The watchdog is tested with an entry retired just short of the threshold and with one held past twice the threshold. These catch an off-by-one age compare and a flag that never latches.

// File: rtl/lat_pkg.sv
package lat_pkg;
  typedef enum logic [2:0] {
    K_READ = 3'd0, K_FETCH = 3'd1, K_STORE = 3'd2, K_FLUSH = 3'd3,
    K_PAIR_RD = 3'd4, K_PAIR_WR = 3'd5, K_LOCK_RD = 3'd6, K_LOCK_WR = 3'd7
  } kind_e;

  typedef enum logic [3:0] {
    P_LOAD = 4'd0, P_FETCH = 4'd1, P_STORE = 4'd2, P_FLUSH = 4'd3,
    P_LINKED = 4'd4, P_COND = 4'd5, P_LOCK_RD = 4'd6, P_LOCK_WR = 4'd7,
    P_RMW_RD = 4'd8
  } prim_e;

  typedef enum logic [2:0] {
    S_LOAD = 3'd0, S_FETCH = 3'd1, S_STORE = 3'd2, S_FLUSH = 3'd3,
    S_ATOMIC = 3'd4
  } sec_e;

  typedef enum logic [1:0] {
    ST_ISSUED = 2'd0, ST_ALIASED = 2'd1, ST_FULL = 2'd2
  } stat_e;
endpackage

// File: rtl/req_classify.sv
module req_classify
  import lat_pkg::*;
(
  input  kind_e kind,
  input  logic  store_check,
  output prim_e prim,
  output sec_e  sec,
  output logic  to_write
);
  always_comb begin
    prim = P_LOAD;
    sec  = S_LOAD;
    unique case (kind)
      K_READ:    begin
                   prim = store_check ? P_RMW_RD : P_LOAD;
                   sec  = store_check ? S_STORE  : S_LOAD;
                 end
      K_FETCH:   begin prim = P_FETCH;   sec = S_FETCH;  end
      K_STORE:   begin prim = P_STORE;   sec = S_STORE;  end
      K_FLUSH:   begin prim = P_FLUSH;   sec = S_FLUSH;  end
      K_PAIR_RD: begin prim = P_LINKED;  sec = S_ATOMIC; end
      K_PAIR_WR: begin prim = P_COND;    sec = S_ATOMIC; end
      K_LOCK_RD: begin prim = P_LOCK_RD; sec = S_STORE;  end
      K_LOCK_WR: begin prim = P_LOCK_WR; sec = S_STORE;  end
      default:   begin prim = P_LOAD;    sec = S_LOAD;   end
    endcase
    to_write = !(prim == P_LOAD || prim == P_FETCH);
  end
endmodule

// File: rtl/line_cam.sv
module line_cam #(
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 26,
  parameter int TS_W   = 12,
  parameter int THRESH = 1024,
  localparam int OCC_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] look_tag,
  input  logic             alloc_en,
  input  logic [TS_W-1:0]  now,
  input  logic             free_en,
  input  logic [TAG_W-1:0] free_tag,
  output logic             look_hit,
  output logic             free_hit,
  output logic             has_room,
  output logic             any_old,
  output logic [OCC_W-1:0] occ
);
  logic [DEPTH-1:0] vld_q, vld_n;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [TS_W-1:0]  stamp_q [DEPTH];
  logic [IDX_W-1:0] slot;
  logic [TS_W-1:0]  age;

  always_comb begin
    look_hit = 1'b0;
    free_hit = 1'b0;
    any_old  = 1'b0;
    has_room = 1'b0;
    slot     = '0;
    occ      = '0;
    age      = '0;
    vld_n    = vld_q;
    for (int i = 0; i < DEPTH; i++) begin
      age = now - stamp_q[i];
      if (vld_q[i] && tag_q[i] == look_tag) look_hit = 1'b1;
      if (vld_q[i] && age >= TS_W'(THRESH)) any_old = 1'b1;
      if (vld_q[i] && tag_q[i] == free_tag) begin
        free_hit = 1'b1;
        if (free_en) vld_n[i] = 1'b0;
      end
      if (!vld_q[i] && !has_room) begin
        has_room = 1'b1;
        slot     = IDX_W'(i);
      end
      occ = occ + OCC_W'(vld_q[i]);
    end
    if (alloc_en && has_room) vld_n[slot] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_n;
  end

  always_ff @(posedge clk) begin
    if (alloc_en && has_room) begin
      tag_q[slot]   <= look_tag;
      stamp_q[slot] <= now;
    end
  end

  // R3
  no_dup_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && has_room) |-> !look_hit);
endmodule

// File: rtl/age_watchdog.sv
module age_watchdog #(
  parameter int THRESH = 1024,
  localparam int WD_W  = $clog2(THRESH) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic busy,
  input  logic any_old,
  output logic deadlock
);
  logic            armed_q, armed_n, dl_n, tick;
  logic [WD_W-1:0] cnt_q, cnt_n;

  always_comb begin
    tick    = armed_q && (cnt_q == WD_W'(THRESH - 1));
    armed_n = arm || (armed_q && !(tick && !busy));
    cnt_n   = (!armed_q || tick) ? '0 : cnt_q + 1'b1;
    dl_n    = deadlock || (tick && any_old);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      cnt_q    <= '0;
      deadlock <= 1'b0;
    end else begin
      armed_q  <= armed_n;
      cnt_q    <= cnt_n;
      deadlock <= dl_n;
    end
  end

  // R9
  dl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deadlock |=> deadlock);
  // R9
  dl_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deadlock) |-> $past(any_old));
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] value
);
  logic [W-1:0] value_n;

  always_comb value_n = (inc && value != '1) ? value + 1'b1 : value;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else        value <= value_n;
  end

  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (value == '1) |=> (value == '1));
endmodule

// File: rtl/line_alias_tracker.sv
module line_alias_tracker
  import lat_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 6,
  parameter int SIZE_W   = 4,
  parameter int RD_DEPTH = 4,
  parameter int WR_DEPTH = 4,
  parameter int MAX_OUT  = 6,
  parameter int THRESH   = 1024,
  parameter int ILAT     = 1,
  parameter int DLAT     = 2,
  parameter int LAT_W    = 8,
  parameter int EV_W     = 16,
  localparam int LINE_W  = ADDR_W - LINE_OFF,
  localparam int OCW     = $clog2(RD_DEPTH + WR_DEPTH + 1),
  localparam int TS_W    = $clog2(THRESH) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [2:0]        req_kind,
  input  logic              req_store_check,
  input  logic              cpl_valid,
  input  logic [LINE_W-1:0] cpl_line,
  input  logic              cpl_write,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic              iss_valid,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [SIZE_W-1:0] iss_size,
  output logic [3:0]        iss_prim,
  output logic [2:0]        iss_sec,
  output logic [LAT_W-1:0]  iss_lat,
  output logic              cpl_err,
  output logic [OCW-1:0]    out_count,
  output logic [EV_W-1:0]   alias_st_ld,
  output logic [EV_W-1:0]   alias_st_st,
  output logic [EV_W-1:0]   alias_ld_ld,
  output logic [EV_W-1:0]   alias_ld_st,
  output logic              deadlock
);
  localparam int RO_W = $clog2(RD_DEPTH + 1);
  localparam int WO_W = $clog2(WR_DEPTH + 1);

  if (ILAT == 0 || DLAT == 0) begin : g_bad_lat
    $error("hit latencies must be nonzero");
  end

  prim_e            prim;
  sec_e             sec;
  stat_e            stat_n;
  logic             to_wr, full, aliased, accept, cpl_hit;
  logic             rd_hit, wr_hit, rd_fhit, wr_fhit, rd_room, wr_room;
  logic             rd_old, wr_old;
  logic [RO_W-1:0]  rd_occ;
  logic [WO_W-1:0]  wr_occ;
  logic [LINE_W-1:0] line;
  logic [TS_W-1:0]  now_q;
  logic [3:0]       ev_inc;
  logic [EV_W-1:0]  ev_val [4];
  logic [LAT_W-1:0] lat;

  assign line = req_addr[ADDR_W-1:LINE_OFF];

  req_classify u_cls (
    .kind(kind_e'(req_kind)), .store_check(req_store_check),
    .prim(prim), .sec(sec), .to_write(to_wr)
  );

  line_cam #(.DEPTH(RD_DEPTH), .TAG_W(LINE_W), .TS_W(TS_W), .THRESH(THRESH)) u_rd (
    .clk(clk), .rst_n(rst_n), .look_tag(line), .alloc_en(accept && !to_wr),
    .now(now_q), .free_en(cpl_valid && !cpl_write), .free_tag(cpl_line),
    .look_hit(rd_hit), .free_hit(rd_fhit), .has_room(rd_room),
    .any_old(rd_old), .occ(rd_occ)
  );

  line_cam #(.DEPTH(WR_DEPTH), .TAG_W(LINE_W), .TS_W(TS_W), .THRESH(THRESH)) u_wr (
    .clk(clk), .rst_n(rst_n), .look_tag(line), .alloc_en(accept && to_wr),
    .now(now_q), .free_en(cpl_valid && cpl_write), .free_tag(cpl_line),
    .look_hit(wr_hit), .free_hit(wr_fhit), .has_room(wr_room),
    .any_old(wr_old), .occ(wr_occ)
  );

  always_comb begin
    out_count = OCW'(rd_occ) + OCW'(wr_occ);
    full      = (out_count >= OCW'(MAX_OUT)) || (to_wr ? !wr_room : !rd_room);
    aliased   = rd_hit || wr_hit;
    accept    = req_valid && !full && !aliased;
    stat_n    = full ? ST_FULL : (aliased ? ST_ALIASED : ST_ISSUED);
    cpl_hit   = cpl_write ? wr_fhit : rd_fhit;
    lat       = (sec == S_FETCH) ? LAT_W'(ILAT) : LAT_W'(DLAT);
    ev_inc[0] = req_valid && !full &&  to_wr && rd_hit;
    ev_inc[1] = req_valid && !full &&  to_wr && wr_hit && !rd_hit;
    ev_inc[2] = req_valid && !full && !to_wr && rd_hit && !wr_hit;
    ev_inc[3] = req_valid && !full && !to_wr && wr_hit;
  end

  for (genvar g = 0; g < 4; g++) begin : g_ev
    sat_counter #(.W(EV_W)) u_ev (
      .clk(clk), .rst_n(rst_n), .inc(ev_inc[g]), .value(ev_val[g])
    );
  end

  assign alias_st_ld = ev_val[0];
  assign alias_st_st = ev_val[1];
  assign alias_ld_ld = ev_val[2];
  assign alias_ld_st = ev_val[3];

  age_watchdog #(.THRESH(THRESH)) u_wd (
    .clk(clk), .rst_n(rst_n), .arm(accept), .busy(out_count != '0),
    .any_old(rd_old || wr_old), .deadlock(deadlock)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q      <= '0;
      rsp_valid  <= 1'b0;
      rsp_status <= 2'd0;
      iss_valid  <= 1'b0;
      iss_prim   <= 4'd0;
      iss_sec    <= 3'd0;
      iss_lat    <= '0;
      iss_addr   <= '0;
      iss_size   <= '0;
      cpl_err    <= 1'b0;
    end else begin
      now_q     <= now_q + 1'b1;
      rsp_valid <= req_valid;
      iss_valid <= accept;
      cpl_err   <= cpl_valid && !cpl_hit;
      if (req_valid) begin
        rsp_status <= stat_n;
        iss_prim   <= prim;
        iss_sec    <= sec;
        iss_lat    <= lat;
        iss_addr   <= req_addr;
        iss_size   <= req_size;
      end
    end
  end

  // R12
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_count <= OCW'(MAX_OUT));
  // R3
  excl_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_hit && wr_hit));
  // R8
  iss_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (iss_lat != '0 && rsp_valid && rsp_status == 2'd0));
  // R10
  bad_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_hit && !req_valid) |=> $stable(out_count));
  // R1
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && out_count >= OCW'(MAX_OUT) && !cpl_valid) |=>
      (rsp_status == 2'd2 && !iss_valid && $stable(out_count)));
endmodule

// File: tb/line_alias_tracker_bench.sv
module line_alias_tracker_bench;
  localparam int ADDR_W = 32, LINE_OFF = 6, SIZE_W = 4;
  localparam int RD = 4, WR = 4, MAXO = 6, THR = 64;
  localparam int IL = 3, DL = 5, LW = 8, EW = 3;
  localparam int LINE_W = ADDR_W - LINE_OFF;
  localparam int OCW = $clog2(RD + WR + 1);
  localparam int EVMAX = (1 << EW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_store_check = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [SIZE_W-1:0] req_size = '0;
  logic [2:0] req_kind = '0;
  logic cpl_valid = 1'b0, cpl_write = 1'b0;
  logic [LINE_W-1:0] cpl_line = '0;
  logic rsp_valid, iss_valid, cpl_err, deadlock;
  logic [1:0] rsp_status;
  logic [ADDR_W-1:0] iss_addr;
  logic [SIZE_W-1:0] iss_size;
  logic [3:0] iss_prim;
  logic [2:0] iss_sec;
  logic [LW-1:0] iss_lat;
  logic [OCW-1:0] out_count;
  logic [EW-1:0] a_sl, a_ss, a_ll, a_ls;

  line_alias_tracker #(.ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF), .SIZE_W(SIZE_W),
    .RD_DEPTH(RD), .WR_DEPTH(WR), .MAX_OUT(MAXO), .THRESH(THR), .ILAT(IL),
    .DLAT(DL), .LAT_W(LW), .EV_W(EW)) u_line_alias_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_kind(req_kind), .req_store_check(req_store_check),
    .cpl_valid(cpl_valid), .cpl_line(cpl_line), .cpl_write(cpl_write),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .iss_valid(iss_valid),
    .iss_addr(iss_addr), .iss_size(iss_size), .iss_prim(iss_prim),
    .iss_sec(iss_sec), .iss_lat(iss_lat), .cpl_err(cpl_err),
    .out_count(out_count), .alias_st_ld(a_sl), .alias_st_st(a_ss),
    .alias_ld_ld(a_ll), .alias_ld_st(a_ls), .deadlock(deadlock)
  );

  always #10 clk = ~clk;

  typedef struct {
    int st; int prim; int sec; int lat; logic [ADDR_W-1:0] addr; int size; string tag;
  } exp_t;
  exp_t exp_q[$];
  bit rd_set[int], wr_set[int];
  int mev[4];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic void classify(int kind, bit sc, output int p, output int s);
    case (kind)
      0: begin p = sc ? 8 : 0; s = sc ? 2 : 0; end
      1: begin p = 1; s = 1; end
      2: begin p = 2; s = 2; end
      3: begin p = 3; s = 3; end
      4: begin p = 4; s = 4; end
      5: begin p = 5; s = 4; end
      6: begin p = 6; s = 2; end
      default: begin p = 7; s = 2; end
    endcase
  endfunction

  function automatic void bump(int i);
    if (mev[i] < EVMAX) mev[i]++;
  endfunction

  task automatic send(int kind, int ln, bit sc, int size, string tag);
    exp_t e;
    int p, s, cnt;
    bit isw;
    classify(kind, sc, p, s);
    isw = !(p == 0 || p == 1);
    cnt = rd_set.num() + wr_set.num();
    e.prim = p; e.sec = s; e.lat = (s == 1) ? IL : DL;
    e.addr = (ADDR_W'(ln) << LINE_OFF) | ADDR_W'(ln % 61); e.size = size; e.tag = tag;
    if (cnt >= MAXO || (isw ? wr_set.num() >= WR : rd_set.num() >= RD)) e.st = 2;
    else if (rd_set.exists(ln) || wr_set.exists(ln)) begin
      e.st = 1;
      if (isw) bump(rd_set.exists(ln) ? 0 : 1);
      else     bump(wr_set.exists(ln) ? 3 : 2);
    end else begin
      e.st = 0;
      if (isw) wr_set[ln] = 1; else rd_set[ln] = 1;
    end
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'(kind); req_store_check = sc;
    req_addr = e.addr; req_size = SIZE_W'(size);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic complete(int ln, bit w, string tag);
    bit expe;
    expe = w ? !wr_set.exists(ln) : !rd_set.exists(ln);
    if (w) wr_set.delete(ln); else rd_set.delete(ln);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_line = LINE_W'(ln); cpl_write = w;
    @(negedge clk);
    cpl_valid = 1'b0;
    chk(cpl_err == expe, tag, cpl_err, expe);
  endtask

  task automatic chk_counters(string tag);
    chk(a_sl == EW'(mev[0]), {tag, " st_ld"}, a_sl, mev[0]);
    chk(a_ss == EW'(mev[1]), {tag, " st_st"}, a_ss, mev[1]);
    chk(a_ll == EW'(mev[2]), {tag, " ld_ld"}, a_ll, mev[2]);
    chk(a_ls == EW'(mev[3]), {tag, " ld_st"}, a_ls, mev[3]);
  endtask

  task automatic chk_count(string tag);
    int n;
    n = rd_set.num() + wr_set.num();
    chk(out_count == OCW'(n), tag, out_count, n);
  endtask

  task automatic drain();
    int ks[$];
    foreach (rd_set[k]) ks.push_back(k);
    foreach (ks[i]) complete(ks[i], 0, "R10 drain rd");
    ks.delete();
    foreach (wr_set[k]) ks.push_back(k);
    foreach (ks[i]) complete(ks[i], 1, "R10 drain wr");
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R11 unexpected response", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rsp_status == 2'(e.st), {e.tag, " status"}, rsp_status, e.st);
        chk(iss_valid == (e.st == 0), {e.tag, " R3 iss_valid"}, iss_valid, e.st == 0);
        if (e.st == 0) begin
          chk(iss_prim == 4'(e.prim), {e.tag, " prim"}, iss_prim, e.prim);
          chk(iss_sec == 3'(e.sec), {e.tag, " sec"}, iss_sec, e.sec);
          chk(iss_lat == LW'(e.lat), {e.tag, " R8 lat"}, iss_lat, e.lat);
          chk(iss_addr == e.addr, {e.tag, " R8 addr"}, int'(iss_addr), int'(e.addr));
          chk(iss_size == SIZE_W'(e.size), {e.tag, " R8 size"}, iss_size, e.size);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(rsp_valid == 0 && iss_valid == 0 && cpl_err == 0, "R11 reset outputs", rsp_valid, 0);
    chk(out_count == 0, "R12 reset count", out_count, 0);
    chk(deadlock == 0, "R9 reset deadlock", deadlock, 0);
    chk_counters("R4 reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // classification: R5 R6 R7 R8
    send(0, 10, 0, 1, "R7 read");
    send(0, 11, 1, 2, "R7 store-check read");
    send(1, 12, 0, 3, "R7 fetch");
    send(2, 13, 0, 4, "R7 store");
    send(3, 14, 0, 5, "R7 flush");
    send(4, 15, 0, 6, "R5 pair read");
    @(negedge clk);
    chk_count("R12 after batch");
    drain();
    chk_count("R12 after drain");
    send(5, 16, 0, 7, "R5 pair write");
    send(6, 17, 0, 8, "R6 locked read");
    send(7, 18, 0, 9, "R6 locked write");
    drain();

    // aliasing R3 R4
    send(0, 20, 0, 1, "R3 load");
    send(0, 20, 0, 1, "R3 load on load");
    send(2, 20, 0, 1, "R3 store on load");
    send(1, 20, 0, 1, "R3 fetch on load");
    complete(20, 0, "R10 retire read");
    send(2, 21, 0, 1, "R3 store");
    send(2, 21, 0, 1, "R3 store on store");
    send(0, 21, 0, 1, "R3 load on store");
    send(3, 21, 0, 1, "R3 flush on store");
    send(4, 21, 0, 1, "R3 pair read on store");
    chk_counters("R4 alias kinds");
    complete(21, 1, "R10 retire write");
    send(0, 20, 0, 1, "R10 reaccept load");
    send(2, 21, 0, 1, "R10 reaccept store");

    // R10 bogus completions
    complete(99, 0, "R10 absent line");
    complete(20, 1, "R10 wrong table");
    chk_count("R10 count unchanged");
    drain();

    // R2 table full, R1 count full
    for (int i = 0; i < 4; i++) send(0, 30 + i, 0, 1, "R2 fill read");
    send(0, 40, 0, 1, "R2 read table full");
    send(2, 41, 0, 1, "R2 store fits");
    send(2, 42, 0, 1, "R2 store fits");
    chk_count("R12 at max");
    send(2, 43, 0, 1, "R1 max reached");
    send(2, 41, 0, 1, "R1 full beats alias");
    send(0, 30, 0, 1, "R1 full beats alias read");
    chk_counters("R1 no event when full");
    drain();

    // R4 saturation
    send(2, 50, 0, 1, "R4 store base");
    for (int i = 0; i < EVMAX + 2; i++) send(2, 50, 0, 1, "R4 saturate");
    chk_counters("R4 saturated");
    drain();

    // R9 watchdog
    chk(deadlock == 0, "R9 quiet so far", deadlock, 0);
    send(0, 60, 0, 1, "R9 young load");
    repeat (THR - 24) @(negedge clk);
    complete(60, 0, "R9 retire young");
    repeat (THR + 8) @(negedge clk);
    chk(deadlock == 0, "R9 young entry no flag", deadlock, 0);
    send(0, 61, 0, 1, "R9 old load");
    repeat (2 * THR + 4) @(negedge clk);
    chk(deadlock == 1, "R9 old entry flags", deadlock, 1);
    complete(61, 0, "R9 retire old");
    repeat (2) @(negedge clk);
    chk(deadlock == 1, "R9 sticky", deadlock, 1);
    chk(exp_q.size() == 0, "R11 all responses seen", exp_q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule